// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home-side coherence directory for a small distributed shared-memory machine made of `N_CLU` clusters. It keeps one directory entry for each line in a small local table. Each entry holds a line state and one presence bit per cluster. Clusters send it read, write and upgrade requests, and replacement hints. For each accepted request the controller updates the entry. It walks the sharers that must be invalidated, or forwards the request to a cluster that holds the line dirty. It then answers the requester with a service class and the latency that class models.

Invalidations go out one cluster per cycle as a one-hot mask, lowest cluster index first. While invalidations or a forward are in progress, the controller stops accepting requests. A forward finishes when the owner returns an acknowledge pulse. The controller sits at cluster `HOME_ID`, so a request is local when it comes from that cluster.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `inv_valid` and `fwd_valid` are 0. Every line starts NOT_CACHED, so the first write to any line sends no invalidation and the first read is served by home.
- R2: A read (`req_op`=0) to a line that is NOT_CACHED or SHARED produces exactly one `rsp_valid` pulse in the cycle after acceptance. It carries `rsp_dst` = requester. Afterwards the line is SHARED with the requester added to the sharers.
- R3: A write (`req_op`=1) or upgrade (`req_op`=2) to a line not held dirty by another cluster does three things. It first raises `inv_valid` for one cycle per other sharer, with `inv_mask` one-hot on that sharer, in ascending cluster order, skipping the requester. It then responds in the cycle after the last invalidation, or in the cycle after acceptance if there is none. The requester is left as the sole EXCLUSIVE holder.
- R4: A read, write or upgrade to a line EXCLUSIVE in another cluster raises `fwd_valid` for exactly one cycle, the cycle after acceptance. In that cycle `fwd_dst` = owner, `fwd_excl` = 1 for write/upgrade and 0 for read, and `cmd_line` = the line. The response comes in the cycle after `ack_valid` is sampled high.
- R5: After a forwarded read, both the old owner and the requester are sharers in state SHARED. After a forwarded write, only the requester holds the line, EXCLUSIVE.
- R6: A replacement hint (`req_op`=3) gives no response and clears only the sender's presence bit. When no bit remains, the line returns to NOT_CACHED. A hint from a non-holder changes nothing.
- R7: `rsp_class` codes are 0 = local, served by home; 1 = local, served by a dirty owner; 2 = remote, served by home; 3 = three-hop via a dirty third party. `rsp_lat` is 30, 100, 100 and 150 cycles for these codes (parameters `LAT_*`).
- R8: A request is local exactly when `req_src` equals `HOME_ID` (default 0).
- R9: `req_ready` is 0 throughout an invalidation sequence and while waiting for an owner acknowledge. A request presented then is neither accepted nor acted on.
- R10: A request from the cluster that already holds the line EXCLUSIVE is served by home with no forward and no invalidation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 upgrade, 3 replacement hint |
| req_src | input | $clog2(N_CLU) | Requesting cluster index |
| req_line | input | $clog2(N_LINES) | Line index in the table |
| inv_valid | output | 1 | Invalidation issued this cycle |
| inv_mask | output | N_CLU | One-hot target of the invalidation |
| fwd_valid | output | 1 | Forward to dirty owner (one-cycle pulse) |
| fwd_dst | output | $clog2(N_CLU) | Owner cluster index |
| fwd_excl | output | 1 | 1: owner must give up the line; 0: owner keeps a shared copy |
| cmd_line | output | $clog2(N_LINES) | Line addressed by the current invalidation or forward |
| ack_valid | input | 1 | Owner acknowledge of a forward |
| rsp_valid | output | 1 | Response pulse |
| rsp_dst | output | $clog2(N_CLU) | Cluster the response goes to |
| rsp_class | output | 2 | Service class (R7 codes) |
| rsp_lat | output | LATW | Modelled latency in cycles |

## Verification
The bench drives sequences that move lines through every state. Reads grow the sharer set. Writes with zero, several and all fifteen other sharers show whether the invalidation order, the requester skip and the response delay track the sharer count. Forwarded reads and writes, with acknowledges that come at once or after a delay, tell a two-sharer result apart from a single-owner result through the invalidations a later write produces. Hints to sharers, to an owner and from non-holders show whether presence bits clear and whether the line returns to NOT_CACHED. Requesters on and off the home cluster separate the four service classes.

// File: rtl/dirh_pkg.sv
package dirh_pkg;
   typedef enum logic [1:0] {
      LN_NONE = 2'd0,
      LN_SHRD = 2'd1,
      LN_EXCL = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      OP_RD   = 2'd0,
      OP_WR   = 2'd1,
      OP_UPG  = 2'd2,
      OP_HINT = 2'd3
   } req_op_e;

   typedef enum logic [1:0] {
      SV_LOCAL_HOME  = 2'd0,
      SV_LOCAL_OWNER = 2'd1,
      SV_REMOTE_HOME = 2'd2,
      SV_THREE_HOP   = 2'd3
   } svc_e;
endpackage

// File: rtl/dirh_table.sv
module dirh_table
   import dirh_pkg::*;
#(
   parameter int N_CLU   = 16,
   parameter int N_LINES = 8,
   localparam int LW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LW-1:0]    rd_line,
   output line_st_e         rd_st,
   output logic [N_CLU-1:0] rd_pres,
   input  logic             wr_en,
   input  logic [LW-1:0]    wr_line,
   input  line_st_e         wr_st,
   input  logic [N_CLU-1:0] wr_pres
);
   line_st_e         st_a   [N_LINES];
   logic [N_CLU-1:0] pres_a [N_LINES];

   for (genvar g = 0; g < N_LINES; g++) begin : g_ent
      line_st_e         st_r;
      logic [N_CLU-1:0] pr_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_r <= LN_NONE;
            pr_r <= '0;
         end else if (wr_en && (wr_line == LW'(g))) begin
            st_r <= wr_st;
            pr_r <= wr_pres;
         end
      end
      assign st_a[g]   = st_r;
      assign pres_a[g] = pr_r;
   end

   assign rd_st   = st_a[rd_line];
   assign rd_pres = pres_a[rd_line];
endmodule

// File: rtl/dirh_invseq.sv
module dirh_invseq #(
   parameter int N_CLU = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [N_CLU-1:0] load_mask,
   output logic             busy,
   output logic [N_CLU-1:0] cur,
   output logic             last
);
   logic [N_CLU-1:0] pend_q;

   // isolate lowest pending cluster
   assign cur  = pend_q & (~pend_q + N_CLU'(1));
   assign busy = (pend_q != '0);
   assign last = busy && ((pend_q & ~cur) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend_q <= '0;
      else if (load) pend_q <= load_mask;
      else           pend_q <= pend_q & ~cur;
   end
endmodule

// File: rtl/dirh_svc.sv
module dirh_svc
   import dirh_pkg::*;
#(
   parameter int N_CLU           = 16,
   parameter int HOME_ID         = 0,
   parameter int LATW            = 8,
   parameter int LAT_LOCAL_HOME  = 30,
   parameter int LAT_LOCAL_OWNER = 100,
   parameter int LAT_REMOTE_HOME = 100,
   parameter int LAT_THREE_HOP   = 150,
   localparam int CW             = (N_CLU > 1) ? $clog2(N_CLU) : 1
) (
   input  logic [CW-1:0]   src,
   input  logic            via_owner,
   output svc_e            svc,
   output logic [LATW-1:0] lat
);
   logic is_local;
   assign is_local = (src == CW'(HOME_ID));

   always_comb begin
      unique case ({is_local, via_owner})
         2'b10:   begin svc = SV_LOCAL_HOME;  lat = LATW'(LAT_LOCAL_HOME);  end
         2'b11:   begin svc = SV_LOCAL_OWNER; lat = LATW'(LAT_LOCAL_OWNER); end
         2'b00:   begin svc = SV_REMOTE_HOME; lat = LATW'(LAT_REMOTE_HOME); end
         default: begin svc = SV_THREE_HOP;   lat = LATW'(LAT_THREE_HOP);   end
      endcase
   end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dirh_pkg::*;
#(
   parameter int N_CLU           = 16,
   parameter int N_LINES         = 8,
   parameter int HOME_ID         = 0,
   parameter int LATW            = 8,
   parameter int LAT_LOCAL_HOME  = 30,
   parameter int LAT_LOCAL_OWNER = 100,
   parameter int LAT_REMOTE_HOME = 100,
   parameter int LAT_THREE_HOP   = 150,
   localparam int CW             = (N_CLU > 1) ? $clog2(N_CLU) : 1,
   localparam int LW             = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [1:0]       req_op,
   input  logic [CW-1:0]    req_src,
   input  logic [LW-1:0]    req_line,
   output logic             inv_valid,
   output logic [N_CLU-1:0] inv_mask,
   output logic             fwd_valid,
   output logic [CW-1:0]    fwd_dst,
   output logic             fwd_excl,
   output logic [LW-1:0]    cmd_line,
   input  logic             ack_valid,
   output logic             rsp_valid,
   output logic [CW-1:0]    rsp_dst,
   output logic [1:0]       rsp_class,
   output logic [LATW-1:0]  rsp_lat
);
   if (N_CLU < 2) begin : g_bad_clu
      $error("dir_home_ctrl: N_CLU must be at least 2");
   end
   if (N_LINES < 1) begin : g_bad_lines
      $error("dir_home_ctrl: N_LINES must be at least 1");
   end
   if (HOME_ID < 0 || HOME_ID >= N_CLU) begin : g_bad_home
      $error("dir_home_ctrl: HOME_ID out of range");
   end
   if (LAT_THREE_HOP >= (1 << LATW) || LAT_LOCAL_OWNER >= (1 << LATW) ||
       LAT_REMOTE_HOME >= (1 << LATW) || LAT_LOCAL_HOME >= (1 << LATW)) begin : g_bad_lat
      $error("dir_home_ctrl: a latency does not fit in LATW bits");
   end

   typedef enum logic [1:0] {F_IDLE, F_INV, F_FWD} fsm_e;

   function automatic logic [CW-1:0] low_idx(input logic [N_CLU-1:0] v);
      low_idx = '0;
      for (int i = N_CLU - 1; i >= 0; i--) if (v[i]) low_idx = CW'(i);
   endfunction

   fsm_e             fsm_q;
   req_op_e          op;
   logic             acc, is_wr, dirty_rem;
   logic [N_CLU-1:0] src_bit, others;

   line_st_e         rd_st, wr_st;
   logic [N_CLU-1:0] rd_pres, wr_pres;
   logic             wr_en;
   logic [LW-1:0]    wr_line;

   logic [LW-1:0]    ctx_line;
   logic [CW-1:0]    ctx_src;
   logic             ctx_wr;
   logic [N_CLU-1:0] ctx_own;

   logic             inv_load, inv_busy, inv_last;
   logic [N_CLU-1:0] inv_cur;

   logic             fire;
   logic [CW-1:0]    svc_src;
   svc_e             svc;
   logic [LATW-1:0]  svc_lat;

   assign req_ready = (fsm_q == F_IDLE);
   assign acc       = req_valid && req_ready;
   assign op        = req_op_e'(req_op);
   assign is_wr     = (op == OP_WR) || (op == OP_UPG);
   assign src_bit   = N_CLU'(1) << req_src;
   assign others    = rd_pres & ~src_bit;
   assign dirty_rem = (rd_st == LN_EXCL) && !rd_pres[req_src] && (op != OP_HINT);

   dirh_table #(.N_CLU(N_CLU), .N_LINES(N_LINES)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_line (req_line),
      .rd_st   (rd_st),
      .rd_pres (rd_pres),
      .wr_en   (wr_en),
      .wr_line (wr_line),
      .wr_st   (wr_st),
      .wr_pres (wr_pres)
   );

   // entry update: at acceptance for home-served work, at acknowledge for forwards
   always_comb begin
      wr_en   = 1'b0;
      wr_line = req_line;
      wr_st   = rd_st;
      wr_pres = rd_pres;
      if (acc) begin
         if (op == OP_HINT) begin
            wr_en   = 1'b1;
            wr_pres = rd_pres & ~src_bit;
            wr_st   = (wr_pres == '0) ? LN_NONE : rd_st;
         end else if (!dirty_rem) begin
            wr_en   = 1'b1;
            if (is_wr) begin
               wr_st   = LN_EXCL;
               wr_pres = src_bit;
            end else begin
               wr_st   = LN_SHRD;
               wr_pres = rd_pres | src_bit;
            end
         end
      end else if (fsm_q == F_FWD && ack_valid) begin
         wr_en   = 1'b1;
         wr_line = ctx_line;
         if (ctx_wr) begin
            wr_st   = LN_EXCL;
            wr_pres = N_CLU'(1) << ctx_src;
         end else begin
            wr_st   = LN_SHRD;
            wr_pres = ctx_own | (N_CLU'(1) << ctx_src);
         end
      end
   end

   assign inv_load = acc && is_wr && !dirty_rem && (others != '0);

   dirh_invseq #(.N_CLU(N_CLU)) u_inv (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (inv_load),
      .load_mask (others),
      .busy      (inv_busy),
      .cur       (inv_cur),
      .last      (inv_last)
   );

   assign inv_valid = inv_busy;
   assign inv_mask  = inv_cur;

   assign svc_src = (fsm_q == F_IDLE) ? req_src : ctx_src;

   dirh_svc #(
      .N_CLU(N_CLU), .HOME_ID(HOME_ID), .LATW(LATW),
      .LAT_LOCAL_HOME(LAT_LOCAL_HOME), .LAT_LOCAL_OWNER(LAT_LOCAL_OWNER),
      .LAT_REMOTE_HOME(LAT_REMOTE_HOME), .LAT_THREE_HOP(LAT_THREE_HOP)
   ) u_svc (
      .src       (svc_src),
      .via_owner (fsm_q == F_FWD),
      .svc       (svc),
      .lat       (svc_lat)
   );

   always_comb begin
      fire = 1'b0;
      unique case (fsm_q)
         F_IDLE:  fire = acc && (op != OP_HINT) && !dirty_rem && !inv_load;
         F_INV:   fire = inv_last;
         F_FWD:   fire = ack_valid;
         default: fire = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q     <= F_IDLE;
         ctx_line  <= '0;
         ctx_src   <= '0;
         ctx_wr    <= 1'b0;
         ctx_own   <= '0;
         fwd_valid <= 1'b0;
         fwd_dst   <= '0;
         fwd_excl  <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_dst   <= '0;
         rsp_class <= '0;
         rsp_lat   <= '0;
      end else begin
         fwd_valid <= acc && dirty_rem;
         rsp_valid <= fire;
         if (fire) begin
            rsp_dst   <= svc_src;
            rsp_class <= svc;
            rsp_lat   <= svc_lat;
         end
         if (acc) begin
            ctx_line <= req_line;
            ctx_src  <= req_src;
            ctx_wr   <= is_wr;
            ctx_own  <= rd_pres;
            fwd_dst  <= low_idx(rd_pres);
            fwd_excl <= is_wr;
         end
         unique case (fsm_q)
            F_IDLE: begin
               if (acc && dirty_rem) fsm_q <= F_FWD;
               else if (inv_load)    fsm_q <= F_INV;
            end
            F_INV:   if (inv_last)  fsm_q <= F_IDLE;
            F_FWD:   if (ack_valid) fsm_q <= F_IDLE;
            default: fsm_q <= F_IDLE;
         endcase
      end
   end

   assign cmd_line = ctx_line;
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
   parameter int N_CLU           = 16,
   parameter int HOME_ID         = 0,
   parameter int LATW            = 8,
   parameter int LAT_LOCAL_HOME  = 30,
   parameter int LAT_LOCAL_OWNER = 100,
   parameter int LAT_REMOTE_HOME = 100,
   parameter int LAT_THREE_HOP   = 150,
   localparam int CW             = (N_CLU > 1) ? $clog2(N_CLU) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [1:0]       req_op,
   input logic             inv_valid,
   input logic [N_CLU-1:0] inv_mask,
   input logic             fwd_valid,
   input logic             rsp_valid,
   input logic [CW-1:0]    rsp_dst,
   input logic [1:0]       rsp_class,
   input logic [LATW-1:0]  rsp_lat
);
   logic [LATW-1:0] exp_lat;
   always_comb begin
      unique case (rsp_class)
         2'd0:    exp_lat = LATW'(LAT_LOCAL_HOME);
         2'd1:    exp_lat = LATW'(LAT_LOCAL_OWNER);
         2'd2:    exp_lat = LATW'(LAT_REMOTE_HOME);
         default: exp_lat = LATW'(LAT_THREE_HOP);
      endcase
   end

   a_r3_inv_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> $countones(inv_mask) == 1);
   a_r3_inv_ascend: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid && $past(inv_valid) |-> inv_mask > $past(inv_mask));
   a_r9_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid || fwd_valid) |-> !req_ready);
   a_r4_fwd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |=> !fwd_valid);
   a_r7_lat_match: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_lat == exp_lat);
   a_r6_hint_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == 2'd3) |=> !rsp_valid);
   a_r8_local_class: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((rsp_dst == CW'(HOME_ID)) == (rsp_class < 2'd2)));
   a_r3_no_rsp_during_inv: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> !rsp_valid);
endmodule

bind dir_home_ctrl dir_home_chk #(
   .N_CLU(N_CLU), .HOME_ID(HOME_ID), .LATW(LATW),
   .LAT_LOCAL_HOME(LAT_LOCAL_HOME), .LAT_LOCAL_OWNER(LAT_LOCAL_OWNER),
   .LAT_REMOTE_HOME(LAT_REMOTE_HOME), .LAT_THREE_HOP(LAT_THREE_HOP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_op(req_op), .inv_valid(inv_valid), .inv_mask(inv_mask),
   .fwd_valid(fwd_valid), .rsp_valid(rsp_valid), .rsp_dst(rsp_dst),
   .rsp_class(rsp_class), .rsp_lat(rsp_lat)
);

// File: tb/sim_dir_home_ctrl.sv
`timescale 1ns/1ps
module sim_dir_home_ctrl;
   localparam int N    = 16;
   localparam int L    = 8;
   localparam int HOME = 0;
   localparam int CW   = $clog2(N);
   localparam int LW   = $clog2(L);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = '0;
   logic [CW-1:0] req_src = '0;
   logic [LW-1:0] req_line = '0;
   logic          inv_valid;
   logic [N-1:0]  inv_mask;
   logic          fwd_valid;
   logic [CW-1:0] fwd_dst;
   logic          fwd_excl;
   logic [LW-1:0] cmd_line;
   logic          ack_valid = 1'b0;
   logic          rsp_valid;
   logic [CW-1:0] rsp_dst;
   logic [1:0]    rsp_class;
   logic [7:0]    rsp_lat;

   always #4 clk = ~clk;

   dir_home_ctrl #(.N_CLU(N), .N_LINES(L), .HOME_ID(HOME)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_src(req_src), .req_line(req_line),
      .inv_valid(inv_valid), .inv_mask(inv_mask), .fwd_valid(fwd_valid),
      .fwd_dst(fwd_dst), .fwd_excl(fwd_excl), .cmd_line(cmd_line),
      .ack_valid(ack_valid), .rsp_valid(rsp_valid), .rsp_dst(rsp_dst),
      .rsp_class(rsp_class), .rsp_lat(rsp_lat)
   );

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   // behavioural directory model: 0 not cached, 1 shared, 2 exclusive
   int           mst   [L];
   logic [N-1:0] mpres [L];

   task automatic chkeq(input string tag, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int lat_of(input int cls);
      case (cls)
         0: return 30;
         1: return 100;
         2: return 100;
         default: return 150;
      endcase
   endfunction

   task automatic chk_rsp(input int src, input int cls);
      chkeq("R2/R3 rsp_valid", rsp_valid, 1);
      chkeq("R2 rsp_dst", rsp_dst, src);
      chkeq("R7/R8 rsp_class", rsp_class, cls);
      chkeq("R7 rsp_lat", rsp_lat, lat_of(cls));
   endtask

   task automatic xact(input int op, input int src, input int ln, input int ackd);
      logic [N-1:0] sb;
      logic [N-1:0] mask;
      int owner;
      bit loc;
      sb = '0;
      sb[src] = 1'b1;
      loc = (src == HOME);
      @(negedge clk);
      chkeq("R9 ready when idle", req_ready, 1);
      chkeq("R3 no stray inv", inv_valid, 0);
      chkeq("R4 no stray fwd", fwd_valid, 0);
      chkeq("R2 no stray rsp", rsp_valid, 0);
      req_valid = 1'b1; req_op = op[1:0]; req_src = CW'(src); req_line = LW'(ln);
      @(negedge clk);
      req_valid = 1'b0;
      if (op == 3) begin
         chkeq("R6 hint gives no response", rsp_valid, 0);
         mpres[ln][src] = 1'b0;
         if (mpres[ln] == '0) mst[ln] = 0;
      end else if (mst[ln] == 2 && !mpres[ln][src]) begin
         owner = 0;
         for (int i = N - 1; i >= 0; i--) if (mpres[ln][i]) owner = i;
         chkeq("R4 fwd_valid", fwd_valid, 1);
         chkeq("R4 fwd_dst", fwd_dst, owner);
         chkeq("R4 fwd_excl", fwd_excl, (op != 0) ? 1 : 0);
         chkeq("R4 cmd_line", cmd_line, ln);
         chkeq("R9 ready low at forward", req_ready, 0);
         if (ackd > 0) begin
            req_valid = 1'b1; req_op = 2'd1; req_src = CW'((src + 1) % N); req_line = LW'(ln);
         end
         for (int d = 0; d < ackd; d++) begin
            @(negedge clk);
            chkeq("R9 ready low awaiting ack", req_ready, 0);
            chkeq("R4 no rsp before ack", rsp_valid, 0);
            chkeq("R4 fwd single pulse", fwd_valid, 0);
         end
         req_valid = 1'b0;
         ack_valid = 1'b1;
         @(negedge clk);
         ack_valid = 1'b0;
         chk_rsp(src, loc ? 1 : 3);
         if (op == 0) begin
            mst[ln] = 1; mpres[ln] = mpres[ln] | sb;
         end else begin
            mst[ln] = 2; mpres[ln] = sb;
         end
      end else if (op == 0) begin
         chk_rsp(src, loc ? 0 : 2);
         mst[ln] = 1; mpres[ln] = mpres[ln] | sb;
      end else begin
         mask = mpres[ln] & ~sb;
         for (int i = 0; i < N; i++) begin
            if (mask[i]) begin
               chkeq("R3 inv_valid", inv_valid, 1);
               chkeq("R3 inv order one-hot", longint'(inv_mask), longint'(1) << i);
               chkeq("R3 inv cmd_line", cmd_line, ln);
               chkeq("R9 ready low during inv", req_ready, 0);
               @(negedge clk);
            end
         end
         chkeq("R3 inv ended", inv_valid, 0);
         chk_rsp(src, loc ? 0 : 2);
         mst[ln] = 2; mpres[ln] = sb;
      end
   endtask

   initial begin
      for (int i = 0; i < L; i++) begin mst[i] = 0; mpres[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chkeq("R1 reset ready", req_ready, 1);
      chkeq("R1 reset rsp", rsp_valid, 0);
      chkeq("R1 reset inv", inv_valid, 0);
      chkeq("R1 reset fwd", fwd_valid, 0);
      // R1: fresh lines
      xact(1, 3, 0, 0);
      xact(0, 0, 1, 0);
      // R2: sharers build up
      xact(0, 5, 1, 0);
      xact(0, 9, 1, 0);
      xact(0, 2, 1, 0);
      // R3: invalidate 0,2,9 skipping 5
      xact(1, 5, 1, 0);
      // R4/R8: local read to remote dirty owner, delayed ack with a blocked request (R9)
      xact(0, 0, 1, 3);
      // R5: both 0 and 5 must be invalidated
      xact(1, 7, 1, 0);
      // R4: remote write to dirty third party, immediate ack
      xact(1, 12, 1, 0);
      // R5: only 12 owns after forwarded write
      xact(0, 3, 1, 1);
      xact(1, 4, 1, 0);
      // R10: owner re-requests
      xact(0, 4, 1, 0);
      xact(1, 4, 1, 0);
      // R6: hints
      xact(0, 1, 2, 0);
      xact(0, 6, 2, 0);
      xact(3, 1, 2, 0);
      xact(1, 6, 2, 0);
      xact(3, 6, 2, 0);
      xact(0, 9, 2, 0);
      xact(3, 3, 2, 0);
      xact(1, 9, 2, 0);
      // R3: upgrade
      xact(0, 15, 3, 0);
      xact(0, 14, 3, 0);
      xact(2, 14, 3, 0);
      // R3: every cluster shares, then one writes
      for (int c = 0; c < N; c++) xact(0, c, L - 1, 0);
      xact(1, 8, L - 1, 0);
      // R4: forwarded upgrade from home cluster
      xact(2, 0, L - 1, 2);
      @(negedge clk);
      chkeq("R2 final idle rsp", rsp_valid, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule